// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the synchronous command front end of a byte-wide flash memory whose address space is divided into equal erasable blocks. A host writes command bytes over an SRAM-style bus. A write cycle is a clock in which `bus_cs` and `bus_we` are both high. The controller decodes single-cycle commands and two-cycle sequences. It also chooses what a read returns: array data, identifier codes or the status register.

Accepted erase and byte-program operations are issued to an external write engine as one-cycle request pulses, together with a latched address and data byte. The engine reports activity on `eng_busy`. Suspend and resume are also issued as pulses. The controller holds one lock bit per block and a single master lock bit. The lock rules are enforced against `hv_flag`, which indicates that the reset pin is at its high-voltage level.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read source is array (`rd_src`=0), all lock bits and the master lock are clear, no request is active, and the status byte reads 80H while the engine is idle.
- R2: Writing FFH selects array reads (`rd_src`=0). Writing 90H selects identifier reads (`rd_src`=1). Writing 70H selects status reads (`rd_src`=2). In identifier mode the value depends on address bits [1:0]: 0 returns the manufacturer code, 1 returns the device code, 2 returns the addressed block's lock bit in bit 0, and 3 returns the master lock in bit 0.
- R3: Writing 20H and then D0H raises `req_erase` for exactly one cycle, with `req_addr` equal to the address of the D0H cycle. After that, reads return status.
- R4: Writing 40H or 10H and then a second write raises `req_prog` for one cycle. `req_addr` and `req_data` are taken from that second cycle.
- R5: The sequence 60H then 01H sets the lock bit of the block selected by address bits [20:16]. The sequence 60H then D0H clears every block lock bit.
- R6: The sequence 60H then F1H sets the master lock only while `hv_flag` is high. Otherwise status bits 4 and 1 are set and the master lock does not change.
- R7: While the master lock is set, setting a block lock or clearing all block locks requires `hv_flag`. A refused set raises status bits 4 and 1. A refused clear raises status bits 5 and 1.
- R8: An erase or program aimed at a locked block without `hv_flag` issues no request. A refused erase raises status bits 5 and 1, and a refused program raises status bits 4 and 1. With `hv_flag` high, the operation proceeds.
- R9: A second byte after 20H or 60H that is not one of the valid codes sets status bits 5 and 4, issues no request, and leaves reads on status.
- R10: Status error bits 5, 4 and 1 stay set until 50H is written while the engine is idle.
- R11: A reserved command byte in idle, and D0H when nothing is suspended, change neither the read source nor the requests.
- R12: While `eng_busy` is high, only 70H, B0H and D0H-resume take effect. B0H pulses `req_suspend` and sets status bit 6 if the last operation was an erase, or bit 2 if it was a program. D0H while suspended pulses `req_resume` and clears both suspend bits.
- R13: Status bit 7 is the inverse of `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select |
| bus_we | input | 1 | Write strobe; a write cycle is bus_cs and bus_we both high |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 8 | Command or data byte |
| hv_flag | input | 1 | Reset pin at high-voltage level |
| eng_busy | input | 1 | Write engine active |
| rd_src | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| rd_data | output | 8 | Identifier or status byte; 0 in array mode |
| req_erase | output | 1 | One-cycle erase request |
| req_prog | output | 1 | One-cycle program request |
| req_suspend | output | 1 | One-cycle suspend request |
| req_resume | output | 1 | One-cycle resume request |
| req_addr | output | 21 | Address of the last issued request |
| req_data | output | 8 | Data of the last issued program |

## Verification
The decoder is driven with valid two-cycle sequences, with invalid second bytes, and with reserved single bytes. This separates real sequence tracking from decoding one byte at a time. The lock sequences are run at both levels of `hv_flag`, before and after the master lock is set, so that each gate shows up as a request or error that is present or absent. Suspend and resume are tried after an erase and while the engine is busy, and the suspend bit that appears shows whether the operation type was recorded. Ignoring commands while busy is checked with a full erase sequence that must produce no request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ERASE, SQ_PROG, SQ_LOCK} seq_t;
  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_ID = 2'd1, RM_STATUS = 2'd2} rmode_t;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLRERR  = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG_A  = 8'h40;
  localparam logic [7:0] OP_PROG_B  = 8'h10;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_LOCKCFG = 8'h60;
  localparam logic [7:0] OP_LOCKBLK = 8'h01;
  localparam logic [7:0] OP_LOCKMST = 8'hF1;
endpackage

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
  parameter int NBLK  = 32,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_blk,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             clr_all,
  input  logic             set_master,
  output logic [NBLK-1:0]  lock_vec,
  output logic             master
);
  for (genvar g = 0; g < NBLK; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst || clr_all)                        lock_vec[g] <= 1'b0;
      else if (set_blk && blk_idx == BLK_W'(g))  lock_vec[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             master <= 1'b0;
    else if (set_master) master <= 1'b1;
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       set_err_e,
  input  logic       set_err_p,
  input  logic       set_viol,
  input  logic       clr_err,
  input  logic       set_esusp,
  input  logic       set_psusp,
  input  logic       clr_susp,
  output logic       any_susp,
  output logic [7:0] stat
);
  logic err_e, err_p, viol, esusp, psusp;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_e <= 1'b0; err_p <= 1'b0; viol <= 1'b0;
      esusp <= 1'b0; psusp <= 1'b0;
    end else begin
      if (clr_err) begin
        err_e <= 1'b0; err_p <= 1'b0; viol <= 1'b0;
      end else begin
        if (set_err_e) err_e <= 1'b1;
        if (set_err_p) err_p <= 1'b1;
        if (set_viol)  viol  <= 1'b1;
      end
      if (clr_susp) begin
        esusp <= 1'b0; psusp <= 1'b0;
      end else begin
        if (set_esusp) esusp <= 1'b1;
        if (set_psusp) psusp <= 1'b1;
      end
    end
  end

  assign any_susp = esusp | psusp;
  assign stat = {~busy, esusp, err_e, err_p, 1'b0, psusp, viol, 1'b0};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 21,
  parameter int         NBLK     = 32,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              hv_flag,
  input  logic              eng_busy,
  output logic [1:0]        rd_src,
  output logic [7:0]        rd_data,
  output logic              req_erase,
  output logic              req_prog,
  output logic              req_suspend,
  output logic              req_resume,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  localparam int BLK_W = $clog2(NBLK);

  seq_t   seq, seq_n;
  rmode_t mode, mode_n;
  logic   op_erase;
  logic   wr;
  logic [BLK_W-1:0] blk;
  logic [NBLK-1:0]  lock_vec;
  logic   master_lk, any_susp, blk_locked;
  logic [7:0] stat_byte;
  logic   st_err_e;

  logic do_erase, do_prog, do_susp, do_resume;
  logic set_blk, clr_all, set_mst;
  logic e_err, p_err, v_err, c_err;

  assign wr         = bus_cs & bus_we;
  assign blk        = bus_addr[ADDR_W-1 -: BLK_W];
  assign blk_locked = lock_vec[blk];
  assign st_err_e   = stat_byte[5];

  always_comb begin
    seq_n = seq; mode_n = mode;
    do_erase = 1'b0; do_prog = 1'b0; do_susp = 1'b0; do_resume = 1'b0;
    set_blk = 1'b0; clr_all = 1'b0; set_mst = 1'b0;
    e_err = 1'b0; p_err = 1'b0; v_err = 1'b0; c_err = 1'b0;
    if (wr) begin
      if (bus_wdata == OP_CONFIRM && any_susp && (eng_busy || seq == SQ_IDLE)) begin
        do_resume = 1'b1;
        seq_n     = SQ_IDLE;
      end else if (eng_busy) begin
        seq_n = SQ_IDLE;
        if (bus_wdata == OP_STATUS) mode_n = RM_STATUS;
        if (bus_wdata == OP_SUSPEND && !any_susp) do_susp = 1'b1;
      end else begin
        case (seq)
          SQ_IDLE: begin
            case (bus_wdata)
              OP_ARRAY:           mode_n = RM_ARRAY;
              OP_IDENT:           mode_n = RM_ID;
              OP_STATUS:          mode_n = RM_STATUS;
              OP_CLRERR:          c_err  = 1'b1;
              OP_ERASE:           seq_n  = SQ_ERASE;
              OP_PROG_A, OP_PROG_B: seq_n = SQ_PROG;
              OP_LOCKCFG:         seq_n  = SQ_LOCK;
              default: ;
            endcase
          end
          SQ_ERASE: begin
            seq_n = SQ_IDLE; mode_n = RM_STATUS;
            if (bus_wdata != OP_CONFIRM) begin
              e_err = 1'b1; p_err = 1'b1;
            end else if (blk_locked && !hv_flag) begin
              e_err = 1'b1; v_err = 1'b1;
            end else do_erase = 1'b1;
          end
          SQ_PROG: begin
            seq_n = SQ_IDLE; mode_n = RM_STATUS;
            if (blk_locked && !hv_flag) begin
              p_err = 1'b1; v_err = 1'b1;
            end else do_prog = 1'b1;
          end
          default: begin
            seq_n = SQ_IDLE; mode_n = RM_STATUS;
            case (bus_wdata)
              OP_LOCKBLK: if (master_lk && !hv_flag) begin
                            p_err = 1'b1; v_err = 1'b1;
                          end else set_blk = 1'b1;
              OP_LOCKMST: if (!hv_flag) begin
                            p_err = 1'b1; v_err = 1'b1;
                          end else set_mst = 1'b1;
              OP_CONFIRM: if (master_lk && !hv_flag) begin
                            e_err = 1'b1; v_err = 1'b1;
                          end else clr_all = 1'b1;
              default:    begin e_err = 1'b1; p_err = 1'b1; end
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq <= SQ_IDLE; mode <= RM_ARRAY; op_erase <= 1'b0;
      req_erase <= 1'b0; req_prog <= 1'b0;
      req_suspend <= 1'b0; req_resume <= 1'b0;
      req_addr <= '0; req_data <= '0;
      rd_src <= 2'd0; rd_data <= 8'h00;
    end else begin
      seq  <= seq_n;
      mode <= mode_n;
      req_erase   <= do_erase;
      req_prog    <= do_prog;
      req_suspend <= do_susp;
      req_resume  <= do_resume;
      if (do_erase || do_prog) begin
        req_addr <= bus_addr;
        op_erase <= do_erase;
      end
      if (do_prog) req_data <= bus_wdata;
      rd_src <= mode;
      case (mode)
        RM_STATUS: rd_data <= stat_byte;
        RM_ID: case (bus_addr[1:0])
                 2'd0:    rd_data <= MFR_CODE;
                 2'd1:    rd_data <= DEV_CODE;
                 2'd2:    rd_data <= {7'b0, blk_locked};
                 default: rd_data <= {7'b0, master_lk};
               endcase
        default:   rd_data <= 8'h00;
      endcase
    end
  end

  flash_lock_bank #(.NBLK(NBLK)) u_locks (
    .clk(clk), .rst(rst), .set_blk(set_blk), .blk_idx(blk),
    .clr_all(clr_all), .set_master(set_mst),
    .lock_vec(lock_vec), .master(master_lk)
  );

  flash_status_reg u_status (
    .clk(clk), .rst(rst), .busy(eng_busy),
    .set_err_e(e_err), .set_err_p(p_err), .set_viol(v_err), .clr_err(c_err),
    .set_esusp(do_susp & op_erase), .set_psusp(do_susp & ~op_erase),
    .clr_susp(do_resume), .any_susp(any_susp), .stat(stat_byte)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_cs,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic       eng_busy,
  input logic       hv_flag,
  input logic       req_erase,
  input logic       req_prog,
  input logic       req_suspend,
  input logic       req_resume,
  input logic       master,
  input logic       err_e
);
  // R3: requests never overlap
  p_req_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_erase, req_prog, req_suspend, req_resume}));

  // R3: an erase request lasts a single cycle
  p_erase_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    req_erase |=> !req_erase);

  // R12: no new operation is started while the engine is busy
  p_no_req_busy_r12: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> !(req_erase || req_prog));

  // R6: the master lock only rises with the high-voltage flag
  p_master_hv_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(master) |-> $past(hv_flag));

  // R10: the erase error bit only falls after a clear command
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(err_e) |-> $past(bus_cs && bus_we && bus_wdata == 8'h50 && !eng_busy));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .eng_busy(eng_busy), .hv_flag(hv_flag),
  .req_erase(req_erase), .req_prog(req_prog),
  .req_suspend(req_suspend), .req_resume(req_resume),
  .master(master_lk), .err_e(st_err_e)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        hv_flag = 1'b0, eng_busy = 1'b0;
  logic [1:0]  rd_src;
  logic [7:0]  rd_data, req_data;
  logic        req_erase, req_prog, req_suspend, req_resume;
  logic [20:0] req_addr;

  int checks = 0, failures = 0;
  logic c_er, c_pr, c_su, c_re;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hv_flag(hv_flag),
    .eng_busy(eng_busy), .rd_src(rd_src), .rd_data(rd_data),
    .req_erase(req_erase), .req_prog(req_prog),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .req_addr(req_addr), .req_data(req_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    c_er = req_erase; c_pr = req_prog; c_su = req_suspend; c_re = req_resume;
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic peek(input logic [20:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 src", rd_src, 0);
    check("R1 reqs", {req_erase, req_prog, req_suspend, req_resume}, 0);
    wr(0, 8'h90); peek(21'h000003, v); check("R1 master", v, 0);
    peek(21'h1F0002, v); check("R1 lock", v, 0);
    wr(0, 8'h70); peek(0, v); check("R1 status", v, 8'h80);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    wr(0, 8'h90); peek(21'h000000, v);
    check("R2 mfr", v, 8'h5A); check("R2 src id", rd_src, 1);
    peek(21'h000001, v); check("R2 dev", v, 8'hC3);
    wr(0, 8'h70); peek(0, v); check("R2 src status", rd_src, 2);
    wr(0, 8'hFF); peek(0, v); check("R2 src array", rd_src, 0);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    wr(21'h0A0000, 8'h20); check("R3 no early req", c_er, 0);
    wr(21'h0A1234, 8'hD0); check("R3 req", c_er, 1);
    check("R3 addr", req_addr, 21'h0A1234);
    peek(0, v); check("R3 pulse", req_erase, 0);
    check("R3 status", v, 8'h80);
  endtask

  task automatic t_prog();
    wr(0, 8'h40); wr(21'h123456, 8'h3C);
    check("R4 req 40", c_pr, 1); check("R4 addr", req_addr, 21'h123456);
    check("R4 data", req_data, 8'h3C);
    wr(0, 8'h10); wr(21'h0F0001, 8'hA5);
    check("R4 req 10", c_pr, 1); check("R4 data 10", req_data, 8'hA5);
  endtask

  task automatic t_locks();
    logic [7:0] v;
    wr(21'h050000, 8'h60); wr(21'h050000, 8'h01);
    wr(0, 8'h90); peek(21'h05ABC2, v); check("R5 set blk5", v, 1);
    peek(21'h060002, v); check("R5 blk6 clear", v, 0);
    wr(21'h050000, 8'h20); wr(21'h050010, 8'hD0);
    check("R8 erase refused", c_er, 0);
    peek(0, v); check("R8 erase err", v, 8'hA2);
    wr(0, 8'h50); peek(0, v); check("R10 cleared", v, 8'h80);
    wr(21'h050000, 8'h40); wr(21'h050020, 8'h11);
    check("R8 prog refused", c_pr, 0);
    peek(0, v); check("R8 prog err", v, 8'h92);
    wr(0, 8'h70); peek(0, v); check("R10 sticky", v, 8'h92);
    wr(0, 8'h50);
    hv_flag = 1'b1;
    wr(21'h050000, 8'h40); wr(21'h050030, 8'h22);
    check("R8 prog hv", c_pr, 1);
    hv_flag = 1'b0;
    wr(0, 8'h60); wr(0, 8'hD0);
    wr(0, 8'h90); peek(21'h050002, v); check("R5 clear all", v, 0);
  endtask

  task automatic t_seq_err();
    logic [7:0] v;
    wr(0, 8'h20); wr(0, 8'h55);
    check("R9 no req", c_er, 0);
    peek(0, v); check("R9 status", v, 8'hB0); check("R9 src", rd_src, 2);
    wr(0, 8'h60); wr(0, 8'h77);
    peek(0, v); check("R9 lock seq", v, 8'hB0);
    wr(0, 8'h50);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(0, 8'hFF); wr(0, 8'h33);
    check("R11 no req", {c_er, c_pr, c_su, c_re}, 0);
    peek(0, v); check("R11 src", rd_src, 0);
    wr(0, 8'hD0); check("R11 no resume", c_re, 0);
    peek(0, v); check("R11 src after D0", rd_src, 0);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    wr(21'h010000, 8'h20); wr(21'h010000, 8'hD0);
    eng_busy = 1'b1;
    wr(0, 8'hFF); peek(0, v);
    check("R12 FF ignored", rd_src, 2); check("R13 busy", v, 8'h00);
    wr(0, 8'h20); wr(0, 8'hD0); check("R12 erase ignored", c_er, 0);
    wr(0, 8'hB0); check("R12 suspend", c_su, 1);
    peek(0, v); check("R12 esusp busy", v, 8'h40);
    eng_busy = 1'b0;
    peek(0, v); check("R13 ready", v, 8'hC0);
    wr(0, 8'hD0); check("R12 resume", c_re, 1);
    peek(0, v); check("R12 susp cleared", v, 8'h80);
    wr(0, 8'h40); wr(0, 8'h01);
    eng_busy = 1'b1; wr(0, 8'hB0);
    eng_busy = 1'b0; peek(0, v); check("R12 psusp", v, 8'h84);
    wr(0, 8'hD0); peek(0, v); check("R12 psusp cleared", v, 8'h80);
  endtask

  task automatic t_master();
    logic [7:0] v;
    wr(0, 8'h60); wr(0, 8'hF1);
    peek(0, v); check("R6 refused", v, 8'h92);
    wr(0, 8'h50); wr(0, 8'h90); peek(21'h000003, v); check("R6 master low", v, 0);
    hv_flag = 1'b1; wr(0, 8'h60); wr(0, 8'hF1); hv_flag = 1'b0;
    wr(0, 8'h90); peek(21'h000003, v); check("R6 master set", v, 1);
    wr(21'h070000, 8'h60); wr(21'h070000, 8'h01);
    peek(0, v); check("R7 set refused", v, 8'h92);
    wr(0, 8'h90); peek(21'h070002, v); check("R7 blk7 still clear", v, 0);
    wr(0, 8'h50);
    hv_flag = 1'b1; wr(21'h070000, 8'h60); wr(21'h070000, 8'h01); hv_flag = 1'b0;
    wr(0, 8'h60); wr(0, 8'hD0);
    peek(0, v); check("R7 clear refused", v, 8'hA2);
    wr(0, 8'h90); peek(21'h070002, v); check("R7 blk7 locked", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_modes();
    t_erase();
    t_prog();
    t_locks();
    t_seq_err();
    t_reserved();
    t_busy();
    t_master();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule